// File: doc/BRIEF.md
# Successive-Approximation ADC Controller

This block is the digital half of an eight-channel, ten-bit successive-approximation converter. Software programs a byte-wide control register. From that register the block drives the channel code for an external analog multiplexer, the enable for the reference ladder's current path, and the choice of reference source. A conversion starts in one of two ways: software writes the control register with the completion flag cleared, or, when enabled, either edge of an external trigger pin starts it. The block then walks a trial code from the most significant bit downward, one bit per clock-enable tick. It drives each trial code to an external ladder DAC and reads back a single comparator bit.

When the last bit is resolved, the block latches the ten-bit result, sets the completion flag and can raise a sticky interrupt request. The interrupt source is programmable: it is either conversion completion or a trigger edge. Software reads the result through a byte-wide port, either as an eight-bit view of the upper bits or as two bytes that together hold all ten bits.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset the control address reads 0x08 (only the completion flag set), irq_o is 0, all result views read 0 and dac_code_o is 0.
- R2: chan_o follows control bits 2:0 (code n selects channel n), ladder_en_o follows control bit 4 and ref_sel_o follows control bit 7 (0 selects the dedicated reference, 1 the alternate one).
- R3: A write to address 0 with bit 3 at 0 while idle starts a conversion, and control bit 3 reads 0 from the next cycle until completion. A write with bit 3 at 1 starts nothing.
- R4: A conversion first drives 0x200 on dac_code_o. Each tick keeps the current bit when cmp_i is 1 (input at or above the trial level) and clears it otherwise. With a comparator that is high exactly when the input level v is at least the code, the result is min(v, 1023).
- R5: The approximation advances only on cycles with tick_i at 1. The completion edge comes on the tenth tick after the start edge.
- R6: With control bit 5 at 1, a rising or a falling edge on trig_i starts a conversion after a two-flop synchroniser plus one edge-detect cycle, so busy is seen three cycles after the pin changes. With bit 5 at 0 the pin starts nothing.
- R7: A start request from software or from the trigger is ignored while a conversion runs. It neither restarts nor stretches the conversion.
- R8: With control bit 6 at 0, completion sets irq_o. With bit 6 at 1, a synchronised trigger edge sets irq_o whatever bit 5 holds, and completion does not set it.
- R9: irq_o stays set until a write to address 1. If a set and that clearing write fall in the same cycle, the set wins.
- R10: Address 1 reads result bits 9:2. Address 3 reads result bits 9:8 in positions 1:0 with zeros above. Address 2 reads result bits 7:0.
- R11: The result views change only on the completion edge. Reads during a conversion return the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Clock enable for the approximation steps |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 control, 1 eight-bit view, 2 low byte, 3 high byte) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| trig_i | input | 1 | External trigger pin, asynchronous |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial level |
| dac_code_o | output | RES_W | Trial code to the ladder DAC |
| chan_o | output | 3 | Analog channel select |
| ladder_en_o | output | 1 | Reference ladder current path enable |
| ref_sel_o | output | 1 | Reference source select |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The interrupt flag has a set source and a clear source, and the two can meet in one cycle. The bench counts cycles from a software start so that the write to address 1 is sampled on the same edge that resolves the last bit, then checks that irq_o is still 1. A second write on its own must clear it. A start request can also coincide with a running conversion. The bench rewrites the start command in the middle of a conversion and checks that the flag still rises exactly on the tenth tick.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int CTRL_W   = 8;
  localparam int CHAN_W   = 3;
  localparam int B_FLAG   = 3;
  localparam int B_LADDER = 4;
  localparam int B_TRGEN  = 5;
  localparam int B_IRQSRC = 6;
  localparam int B_REFSEL = 7;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_VIEW8 = 2'd1,
    A_LO    = 2'd2,
    A_HI    = 2'd3
  } addr_e;
endpackage

// File: rtl/sar_trig_sync.sv
module sar_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic edge_o
);
  // STAGES sync flops plus one history flop for edge detect
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], trig_i};
  end

  assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o
);
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [RES_W-1:0] MSB = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [RES_W-1:0] ONE = {{(RES_W-1){1'b0}}, 1'b1};
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W-1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] trial_q, result_q, bit_m, kept;
  logic             last;

  always_comb begin
    bit_m  = ONE << idx_q;
    kept   = cmp_i ? trial_q : (trial_q & ~bit_m);
    last   = (idx_q == '0);
    done_o = busy_q & tick_i & last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      idx_q    <= '0;
      trial_q  <= '0;
      result_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        idx_q   <= TOP_IDX;
        trial_q <= MSB;
      end
    end else if (tick_i) begin
      if (last) begin
        busy_q   <= 1'b0;
        trial_q  <= kept;
        result_q <= kept;
      end else begin
        idx_q   <= idx_q - 1'b1;
        trial_q <= kept | (bit_m >> 1);
      end
    end
  end

  assign busy_o   = busy_q;
  assign trial_o  = trial_q;
  assign result_o = result_q;

  AST_TRIAL_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> trial_q == MSB); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !tick_i |=> busy_q && $stable(trial_q) && $stable(idx_q)); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(result_q)); // R11
endmodule

// File: rtl/sar_rd_mux.sv
module sar_rd_mux
  import sar_adc_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic [1:0]       addr_i,
  input  logic [7:0]       ctrl_i,
  input  logic [RES_W-1:0] result_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] hi_byte;

  always_comb begin
    hi_byte = '0;
    hi_byte[RES_W-9:0] = result_i[RES_W-1:8];
    unique case (addr_e'(addr_i))
      A_CTRL:  rdata_o = ctrl_i;
      A_VIEW8: rdata_o = result_i[RES_W-1 -: 8];
      A_LO:    rdata_o = result_i[7:0];
      A_HI:    rdata_o = hi_byte;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic             trig_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_code_o,
  output logic [2:0]       chan_o,
  output logic             ladder_en_o,
  output logic             ref_sel_o,
  output logic             irq_o
);
  localparam logic [7:0] FLAG_M = 8'(1 << B_FLAG);

  logic [7:0]       ctrl_q;
  logic             flag_q, irq_q;
  logic             trig_edge, busy, done, sw_start, start_req, irq_set, irq_clr;
  logic [RES_W-1:0] result;

  sar_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .trig_i, .edge_o(trig_edge)
  );

  assign sw_start  = wr_en_i && (addr_e'(addr_i) == A_CTRL) && !wdata_i[B_FLAG];
  assign start_req = sw_start || (ctrl_q[B_TRGEN] && trig_edge);
  assign irq_clr   = wr_en_i && (addr_e'(addr_i) == A_VIEW8);
  assign irq_set   = ctrl_q[B_IRQSRC] ? trig_edge : done;

  sar_engine #(.RES_W(RES_W)) u_eng (
    .clk_i, .rst_ni,
    .start_i (start_req),
    .tick_i,
    .cmp_i,
    .busy_o  (busy),
    .done_o  (done),
    .trial_o (dac_code_o),
    .result_o(result)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      flag_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en_i && addr_e'(addr_i) == A_CTRL) ctrl_q <= wdata_i & ~FLAG_M;
      if (done)                    flag_q <= 1'b1;
      else if (start_req && !busy) flag_q <= 1'b0;
      // set wins over a same-cycle clear
      if (irq_set)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  sar_rd_mux #(.RES_W(RES_W)) u_rd (
    .addr_i,
    .ctrl_i  (ctrl_q | (flag_q ? FLAG_M : 8'h00)),
    .result_i(result),
    .rdata_o
  );

  assign chan_o      = ctrl_q[CHAN_W-1:0];
  assign ladder_en_o = ctrl_q[B_LADDER];
  assign ref_sel_o   = ctrl_q[B_REFSEL];
  assign irq_o       = irq_q;

  AST_FLAG_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q != busy); // R3
  AST_TRIG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && !sw_start && !ctrl_q[B_TRGEN] |=> !busy); // R6
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !done |=> busy); // R7
  AST_IRQ_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && !ctrl_q[B_IRQSRC] |=> irq_q); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !irq_clr |=> irq_q); // R9
endmodule

// File: tb/sar_adc_ctrl_tb_top.sv
module sar_adc_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       trig = 1'b0;
  logic       cmp;
  logic [9:0] dac;
  logic [2:0] chan;
  logic       ladder_en, ref_sel, irq;
  logic [10:0] vin = 11'd0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  // comparator model: high when input level is at or above the trial code
  assign cmp = ({1'b0, dac} <= vin);

  sar_adc_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .trig_i(trig),
    .cmp_i(cmp), .dac_code_o(dac), .chan_o(chan), .ladder_en_o(ladder_en),
    .ref_sel_o(ref_sel), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_done(input string req);
    logic [7:0] d;
    for (int i = 0; i < 200; i++) begin
      rd(2'd0, d);
      if (d[3]) return;
    end
    chk(req, 0, 1);
  endtask

  task automatic read_result(output int r);
    logic [7:0] hi, lo;
    rd(2'd3, hi);
    rd(2'd2, lo);
    r = {hi, lo};
  endtask

  task automatic toggle_trig();
    @(negedge clk);
    trig = ~trig;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    logic [7:0] d, v8, hi, lo;
    int r, exp, prev;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 8'h08);
    chk("R1 irq", irq, 0);
    chk("R1 dac", dac, 0);
    rd(2'd1, d); chk("R1 view8", d, 0);
    read_result(r); chk("R1 result", r, 0);

    // R2 control fields to outputs
    wr(2'd0, 8'h9D);
    chk("R2 chan", chan, 5); chk("R2 ladder", ladder_en, 1); chk("R2 ref", ref_sel, 1);
    rd(2'd0, d); chk("R3 write of 1 starts nothing", d, 8'h9D);
    wr(2'd0, 8'h0A);
    chk("R2 chan", chan, 2); chk("R2 ladder", ladder_en, 0); chk("R2 ref", ref_sel, 0);

    // R4 R10 exhaustive level sweep, plus an over-range level
    for (int v = 0; v <= 1024; v++) begin
      vin = (v == 1024) ? 11'd1500 : 11'(v);
      exp = (v == 1024) ? 1023 : v;
      wr(2'd0, 8'(v % 8));
      if (v == 5) begin
        chk("R4 first trial", dac, 10'h200);
        rd(2'd0, d); chk("R3 flag low while running", d[3], 0);
      end
      wait_done("R4 completion");
      rd(2'd3, hi); rd(2'd2, lo); rd(2'd1, v8);
      if ({hi, lo} != exp || v8 != 8'(exp >> 2) || hi[7:2] != 0)
        chk("R10 R4 views", {hi, lo, v8}, {8'(exp >> 8), 8'(exp), 8'(exp >> 2)});
      else checks++;
    end
    chk("R2 chan after sweep", chan, 0);

    // R5 no progress without tick
    vin = 11'd613;
    tick = 1'b0;
    wr(2'd0, 8'h00);
    repeat (20) @(posedge clk);
    rd(2'd0, d); chk("R5 stalled flag", d[3], 0);
    chk("R5 stalled dac", dac, 10'h200);
    tick = 1'b1;
    wait_done("R5 completion");
    read_result(r); chk("R5 result", r, 613);

    // R7 R11 restart while busy ignored; result held mid-conversion
    vin = 11'd300;
    wr(2'd0, 8'h00);
    rd(2'd1, d); chk("R11 view8 held", d, 613 >> 2);
    repeat (3) @(posedge clk);
    wr(2'd0, 8'h00);
    repeat (5) @(posedge clk);
    rd(2'd0, d); chk("R7 busy before tenth tick", d[3], 0);
    rd(2'd0, d); chk("R7 done on tenth tick", d[3], 1);
    read_result(r); chk("R7 result", r, 300);

    // R9 collision: clear write on the completion edge
    wr(2'd1, 8'h00);
    chk("R9 cleared", irq, 0);
    vin = 11'd77;
    wr(2'd0, 8'h00);
    repeat (9) @(posedge clk);
    wr(2'd1, 8'h00);
    @(negedge clk); chk("R9 set wins over clear", irq, 1);
    repeat (5) @(posedge clk);
    @(negedge clk); chk("R9 sticky", irq, 1);
    wr(2'd1, 8'h00);
    @(negedge clk); chk("R9 clear", irq, 0);

    // R8 trigger-edge interrupt source, trigger start disabled (rising edge)
    wr(2'd0, 8'h48);
    toggle_trig();
    repeat (3) @(posedge clk);
    @(negedge clk); chk("R8 edge irq", irq, 1);
    rd(2'd0, d); chk("R6 bit5 off no start", d[3], 1);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h40);
    wait_done("R8 completion");
    chk("R8 completion no irq when src=1", irq, 0);

    // R6 falling-edge start
    vin = 11'd700;
    wr(2'd0, 8'h2D);
    toggle_trig();
    repeat (3) @(posedge clk);
    rd(2'd0, d); chk("R6 falling edge start", d[3], 0);
    wait_done("R6 completion");
    read_result(r); chk("R6 result", r, 700);
    chk("R8 completion irq when src=0", irq, 1);

    // R6 rising-edge start
    vin = 11'd123;
    toggle_trig();
    repeat (3) @(posedge clk);
    rd(2'd0, d); chk("R6 rising edge start", d[3], 0);
    wait_done("R6 completion");
    read_result(r); chk("R6 result", r, 123);

    // R6 disabled trigger ignored
    prev = r;
    vin = 11'd900;
    wr(2'd0, 8'h08);
    toggle_trig();
    repeat (4) @(posedge clk);
    rd(2'd0, d); chk("R6 ignored trigger", d[3], 1);
    read_result(r); chk("R6 result unchanged", r, prev);

    summary();
  end
endmodule